// File: doc/BRIEF.md
# Flash Partition Read Router

This block decides, for every read issued to a four-plane flash array, whether the caller receives array content or the status register. The array is cut into four planes of equal size, and the two most significant address bits give the plane. A 3-bit partition code groups neighbouring planes into partitions. Bit i of the code set places a partition edge between plane i and plane i+1, so 3'b111 gives four single-plane partitions and 3'b000 gives one partition covering all planes.

A program or erase is announced with a start strobe, a kind and the target plane, and it is retired with a done strobe. While an ordinary block operation runs, reads that land in the busy partition see status and reads elsewhere see array data. That is dual-work reading. A full-chip erase or a one-time-programmable area write blocks dual work: every read returns status, and a read aimed outside the busy partition is flagged as an illegal dual-work request. Writes of the partition code are refused while an operation runs. The default grouping at reset depends on whether the device has its parameter blocks at the top or at the bottom of the array.

Top module: `flash_part_router`

## Requirements
- R1: After reset, `cfgCode` is 3'b100 when `TOP_PARAM`=1 (planes 0..2 form one partition, plane 3 its own) and 3'b001 when `TOP_PARAM`=0. `opBusy` and `rdValid` are 0.
- R2: The plane of an address is its top two bits. The partition of plane p is the number of set code bits at positions below p, so a set bit i splits plane i from plane i+1.
- R3: A read request accepted at a clock edge produces exactly one response at the next edge, with `rdValid`=1 and `rdAddrOut` equal to the request address. An array response carries the `arrayData` value sampled with the request. `rdValid` is 0 in every cycle that does not follow a request.
- R4: While a block operation runs (`opKind` 2'b00 or 2'b11), a read in the busy partition returns `statusData` with `rdIsStatus`=1.
- R5: While a block operation runs, a read in any other partition returns `arrayData` with `rdIsStatus`=0.
- R6: While a full-chip erase (`opKind`=2'b01) or an OTP program (`opKind`=2'b10) runs, every read returns status. `rdIllegal`=1 exactly when the read's partition differs from the busy partition.
- R7: A code write with no operation running updates `cfgCode` at the next edge, and `cfgErr` stays 0.
- R8: A code write during an operation leaves `cfgCode` unchanged and raises `cfgErr` for exactly the one following cycle.
- R9: A start strobe during an operation is ignored, and the kind and target are kept. `opDone` during an operation clears `opBusy` at the next edge.
- R10: A start strobe with no operation running sets `opBusy` at the next edge. Reads use the busy state as it stood before the edge.
- R11: `rdIllegal` is 0 when no operation runs and during block operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Partition code write strobe |
| cfgWdata | input | 3 | Partition code to write |
| cfgCode | output | 3 | Current partition code |
| cfgErr | output | 1 | One-cycle pulse for a refused code write |
| opStart | input | 1 | Embedded operation start strobe |
| opKind | input | 2 | 00/11 block op, 01 full-chip erase, 10 OTP program |
| opPlane | input | 2 | Plane index of the operation target |
| opDone | input | 1 | Embedded operation completion strobe |
| opBusy | output | 1 | An embedded operation is running |
| rdReq | input | 1 | Read request |
| rdAddr | input | ADDR_W | Read word address |
| arrayData | input | DATA_W | Array content for the requested address |
| statusData | input | DATA_W | Current status register value |
| rdValid | output | 1 | Response valid |
| rdData | output | DATA_W | Response data |
| rdIsStatus | output | 1 | Response carries status rather than array data |
| rdIllegal | output | 1 | Response answers an illegal dual-work read |
| rdAddrOut | output | ADDR_W | Address the response answers |

## Verification
Reads sweep every plane while idle, during block operations under the codes 3'b100, 3'b111, 3'b000 and 3'b010, and during both exclusive kinds. This separates a wrong plane-to-partition mapping, an inverted boundary bit and a mix-up of same-partition with other-partition results. Code writes and start strobes issued while busy show whether refusals really leave state untouched. Back-to-back reads show whether data is sampled with the request rather than one cycle late.

// File: rtl/flash_part_pkg.sv
package flash_part_pkg;

  localparam int NUM_PLANES = 4;
  localparam int PLANE_W    = $clog2(NUM_PLANES);
  localparam int CFG_W      = NUM_PLANES - 1;

  localparam logic [CFG_W-1:0] CFG_TOP_DEFAULT = 3'b100;
  localparam logic [CFG_W-1:0] CFG_BOT_DEFAULT = 3'b001;

  typedef enum logic [1:0] {
    OP_BLOCK    = 2'b00,
    OP_CHIP     = 2'b01,
    OP_OTP      = 2'b10,
    OP_BLOCK_ALT = 2'b11
  } opKind_e;

  typedef struct packed {
    logic               busy;
    logic               exclusive;
    logic [PLANE_W-1:0] opPlane;
    logic [CFG_W-1:0]   cfg;
  } ctrlStrobes_t;

  // Partition index of a plane: count of edge bits sitting below it.
  function automatic logic [PLANE_W-1:0] partitionOf(
    input logic [CFG_W-1:0]   cfg,
    input logic [PLANE_W-1:0] plane
  );
    logic [PLANE_W-1:0] n;
    n = '0;
    for (int i = 0; i < CFG_W; i++) begin
      if (PLANE_W'(i) < plane) n = n + PLANE_W'(cfg[i]);
    end
    return n;
  endfunction

endpackage

// File: rtl/flash_part_ctrl.sv
module flash_part_ctrl
  import flash_part_pkg::*;
#(
  parameter bit TOP_PARAM = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWe,
  input  logic [CFG_W-1:0]   cfgWdata,
  input  logic               opStart,
  input  logic [1:0]         opKind,
  input  logic [PLANE_W-1:0] opPlane,
  input  logic               opDone,
  output logic               cfgErr,
  output ctrlStrobes_t       strobes
);

  localparam logic [CFG_W-1:0] CFG_RESET = TOP_PARAM ? CFG_TOP_DEFAULT : CFG_BOT_DEFAULT;

  logic               busyQ;
  logic               exclQ;
  logic [PLANE_W-1:0] planeQ;
  logic [CFG_W-1:0]   cfgQ;
  logic               cfgErrQ;
  logic               kindExcl;

  always_comb begin
    unique case (opKind_e'(opKind))
      OP_CHIP, OP_OTP: kindExcl = 1'b1;
      default:         kindExcl = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgQ    <= CFG_RESET;
      busyQ   <= 1'b0;
      exclQ   <= 1'b0;
      planeQ  <= '0;
      cfgErrQ <= 1'b0;
    end else begin
      cfgErrQ <= cfgWe && busyQ;
      if (cfgWe && !busyQ) cfgQ <= cfgWdata;
      if (busyQ) begin
        if (opDone) busyQ <= 1'b0;
      end else if (opStart) begin
        busyQ  <= 1'b1;
        exclQ  <= kindExcl;
        planeQ <= opPlane;
      end
    end
  end

  assign cfgErr            = cfgErrQ;
  assign strobes.busy      = busyQ;
  assign strobes.exclusive = exclQ;
  assign strobes.opPlane   = planeQ;
  assign strobes.cfg       = cfgQ;

endmodule

// File: rtl/flash_part_dpath.sv
module flash_part_dpath
  import flash_part_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic              rdReq,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] arrayData,
  input  logic [DATA_W-1:0] statusData,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic              rdIsStatus,
  output logic              rdIllegal,
  output logic [ADDR_W-1:0] rdAddrOut
);

  logic [PLANE_W-1:0] rdPlane;
  logic [PLANE_W-1:0] rdPart;
  logic [PLANE_W-1:0] opPart;
  logic               samePart;
  logic               selStatus;
  logic               flagIllegal;

  assign rdPlane     = rdAddr[ADDR_W-1 -: PLANE_W];
  assign rdPart      = partitionOf(strobes.cfg, rdPlane);
  assign opPart      = partitionOf(strobes.cfg, strobes.opPlane);
  assign samePart    = (rdPart == opPart);
  assign selStatus   = strobes.busy && (strobes.exclusive || samePart);
  assign flagIllegal = strobes.busy && strobes.exclusive && !samePart;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid    <= 1'b0;
      rdData     <= '0;
      rdIsStatus <= 1'b0;
      rdIllegal  <= 1'b0;
      rdAddrOut  <= '0;
    end else begin
      rdValid <= rdReq;
      if (rdReq) begin
        rdData     <= selStatus ? statusData : arrayData;
        rdIsStatus <= selStatus;
        rdIllegal  <= flagIllegal;
        rdAddrOut  <= rdAddr;
      end
    end
  end

endmodule

// File: rtl/flash_part_router.sv
module flash_part_router
  import flash_part_pkg::*;
#(
  parameter int ADDR_W    = 21,
  parameter int DATA_W    = 16,
  parameter bit TOP_PARAM = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [2:0]        cfgWdata,
  output logic [2:0]        cfgCode,
  output logic              cfgErr,
  input  logic              opStart,
  input  logic [1:0]        opKind,
  input  logic [1:0]        opPlane,
  input  logic              opDone,
  output logic              opBusy,
  input  logic              rdReq,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] arrayData,
  input  logic [DATA_W-1:0] statusData,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic              rdIsStatus,
  output logic              rdIllegal,
  output logic [ADDR_W-1:0] rdAddrOut
);

  ctrlStrobes_t strobes;

  flash_part_ctrl #(.TOP_PARAM(TOP_PARAM)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWe    (cfgWe),
    .cfgWdata (cfgWdata),
    .opStart  (opStart),
    .opKind   (opKind),
    .opPlane  (opPlane),
    .opDone   (opDone),
    .cfgErr   (cfgErr),
    .strobes  (strobes)
  );

  flash_part_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dpath_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .rdReq      (rdReq),
    .rdAddr     (rdAddr),
    .arrayData  (arrayData),
    .statusData (statusData),
    .rdValid    (rdValid),
    .rdData     (rdData),
    .rdIsStatus (rdIsStatus),
    .rdIllegal  (rdIllegal),
    .rdAddrOut  (rdAddrOut)
  );

  assign cfgCode = strobes.cfg;
  assign opBusy  = strobes.busy;

endmodule

// File: rtl/flash_part_router_chk.sv
module flash_part_router_chk #(
  parameter int ADDR_W = 21,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgWe,
  input logic [2:0]        cfgCode,
  input logic              cfgErr,
  input logic              opStart,
  input logic              opDone,
  input logic              opBusy,
  input logic              rdReq,
  input logic [ADDR_W-1:0] rdAddr,
  input logic [DATA_W-1:0] arrayData,
  input logic              rdValid,
  input logic [DATA_W-1:0] rdData,
  input logic              rdIsStatus,
  input logic              rdIllegal,
  input logic [ADDR_W-1:0] rdAddrOut
);

  assert_resp_follows_req_R3: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |=> (rdValid && rdAddrOut == $past(rdAddr)));

  assert_no_spurious_resp_R3: assert property (@(posedge clk) disable iff (!rstN)
    !rdReq |=> !rdValid);

  assert_array_data_sampled_R3: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && !opBusy) |=> (!rdIsStatus && rdData == $past(arrayData)));

  assert_illegal_is_status_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && rdIllegal) |-> rdIsStatus);

  assert_idle_never_illegal_R11: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && !opBusy) |=> !rdIllegal);

  assert_cfg_refused_R8: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWe && opBusy) |=> (cfgErr && $stable(cfgCode)));

  assert_cfg_err_cause_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(cfgWe && opBusy) |=> !cfgErr);

  assert_start_sets_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    (opStart && !opBusy) |=> opBusy);

  assert_done_clears_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    (opDone && opBusy) |=> !opBusy);

  assert_idle_stays_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!opStart && !opBusy) |=> !opBusy);

endmodule

bind flash_part_router flash_part_router_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .cfgWe      (cfgWe),
  .cfgCode    (cfgCode),
  .cfgErr     (cfgErr),
  .opStart    (opStart),
  .opDone     (opDone),
  .opBusy     (opBusy),
  .rdReq      (rdReq),
  .rdAddr     (rdAddr),
  .arrayData  (arrayData),
  .rdValid    (rdValid),
  .rdData     (rdData),
  .rdIsStatus (rdIsStatus),
  .rdIllegal  (rdIllegal),
  .rdAddrOut  (rdAddrOut)
);

// File: tb/flash_part_router_tb_top.sv
`timescale 1ns/1ps
module flash_part_router_tb_top;

  localparam int ADDR_W = 21;
  localparam int DATA_W = 16;

  typedef struct {
    logic [DATA_W-1:0] data;
    logic              isStatus;
    logic              illegal;
    logic [ADDR_W-1:0] addr;
    string             req;
  } expItem_t;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              cfgWe = 1'b0;
  logic [2:0]        cfgWdata = '0;
  logic [2:0]        cfgCode;
  logic              cfgErr;
  logic              opStart = 1'b0;
  logic [1:0]        opKind = '0;
  logic [1:0]        opPlane = '0;
  logic              opDone = 1'b0;
  logic              opBusy;
  logic              rdReq = 1'b0;
  logic [ADDR_W-1:0] rdAddr = '0;
  logic [DATA_W-1:0] arrayData = '0;
  logic [DATA_W-1:0] statusData = '0;
  logic              rdValid;
  logic [DATA_W-1:0] rdData;
  logic              rdIsStatus;
  logic              rdIllegal;
  logic [ADDR_W-1:0] rdAddrOut;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  expItem_t expQ[$];

  // bench-side model
  logic [2:0] mCfg;
  bit         mBusy;
  bit         mExcl;
  logic [1:0] mPlane;
  int         seq = 0;

  always #2.5 clk = ~clk;

  flash_part_router #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TOP_PARAM(1'b1)) dut_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgWdata(cfgWdata), .cfgCode(cfgCode),
    .cfgErr(cfgErr), .opStart(opStart), .opKind(opKind), .opPlane(opPlane),
    .opDone(opDone), .opBusy(opBusy), .rdReq(rdReq), .rdAddr(rdAddr),
    .arrayData(arrayData), .statusData(statusData), .rdValid(rdValid),
    .rdData(rdData), .rdIsStatus(rdIsStatus), .rdIllegal(rdIllegal),
    .rdAddrOut(rdAddrOut)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int actual, input int expected);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, actual, expected);
    end
  endtask

  function automatic int partOf(input logic [2:0] cfg, input logic [1:0] plane);
    int n = 0;
    for (int b = 0; b < 3; b++) if (b < int'(plane) && cfg[b]) n++;
    return n;
  endfunction

  task automatic doRead(input logic [1:0] plane, input logic [18:0] off, input string req);
    expItem_t it;
    bit same;
    seq++;
    rdAddr     = {plane, off};
    arrayData  = 16'hA000 ^ DATA_W'(seq * 37);
    statusData = 16'h0080 | DATA_W'(seq << 8);
    rdReq      = 1'b1;
    same        = (partOf(mCfg, plane) == partOf(mCfg, mPlane));
    it.isStatus = mBusy && (mExcl || same);
    it.illegal  = mBusy && mExcl && !same;
    it.data     = it.isStatus ? statusData : arrayData;
    it.addr     = rdAddr;
    it.req      = req;
    expQ.push_back(it);
    @(negedge clk);
    rdReq = 1'b0;
  endtask

  task automatic startOp(input logic [1:0] kind, input logic [1:0] plane);
    opStart = 1'b1;
    opKind  = kind;
    opPlane = plane;
    @(negedge clk);
    opStart = 1'b0;
    if (!mBusy) begin
      mBusy  = 1'b1;
      mExcl  = (kind == 2'b01) || (kind == 2'b10);
      mPlane = plane;
    end
    check(opBusy == 1'b1, "R10", "opBusy after start", int'(opBusy), 1);
  endtask

  task automatic doneOp();
    opDone = 1'b1;
    @(negedge clk);
    opDone = 1'b0;
    mBusy = 1'b0;
    check(opBusy == 1'b0, "R9", "opBusy after done", int'(opBusy), 0);
  endtask

  task automatic writeCfg(input logic [2:0] v);
    bit refused;
    refused  = mBusy;
    cfgWe    = 1'b1;
    cfgWdata = v;
    @(negedge clk);
    cfgWe = 1'b0;
    if (!refused) mCfg = v;
    check(cfgCode == mCfg, refused ? "R8" : "R7", "cfgCode after write", int'(cfgCode), int'(mCfg));
    check(cfgErr == refused, refused ? "R8" : "R7", "cfgErr after write", int'(cfgErr), int'(refused));
    @(negedge clk);
    check(cfgErr == 1'b0, "R8", "cfgErr second cycle", int'(cfgErr), 0);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rstN && rdValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R3", "unexpected response", 1, 0);
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        check(rdIsStatus == e.isStatus, e.req, "rdIsStatus", int'(rdIsStatus), int'(e.isStatus));
        check(rdData == e.data, e.req, "rdData", int'(rdData), int'(e.data));
        check(rdIllegal == e.illegal, e.illegal ? "R6" : "R11", "rdIllegal", int'(rdIllegal), int'(e.illegal));
        check(rdAddrOut == e.addr, "R3", "rdAddrOut", int'(rdAddrOut), int'(e.addr));
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      failures++;
      $display("FAIL R3 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    mCfg = 3'b100; mBusy = 0; mExcl = 0; mPlane = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    check(cfgCode == 3'b100, "R1", "cfgCode reset", int'(cfgCode), 4);
    check(opBusy == 1'b0, "R1", "opBusy reset", int'(opBusy), 0);
    check(rdValid == 1'b0, "R1", "rdValid reset", int'(rdValid), 0);

    // R3 R11 idle reads in every plane, back to back
    for (int p = 0; p < 4; p++) doRead(2'(p), 19'h1234 + 19'(p), "R3");
    @(negedge clk);
    check(rdValid == 1'b0, "R3", "rdValid idle", int'(rdValid), 0);

    // default grouping {0,1,2},{3}; block op in plane 3
    startOp(2'b00, 2'd3);
    doRead(2'd3, 19'h00010, "R4");
    doRead(2'd0, 19'h00020, "R5");
    doRead(2'd2, 19'h7FFFF, "R5");
    writeCfg(3'b111);                 // R8 refused
    startOp(2'b01, 2'd0);             // R9 ignored start
    doRead(2'd0, 19'h00030, "R9");
    doRead(2'd3, 19'h00000, "R4");
    doneOp();
    doRead(2'd3, 19'h00040, "R9");

    // four partitions
    writeCfg(3'b111);                 // R7
    startOp(2'b11, 2'd1);
    doRead(2'd1, 19'h00050, "R4");
    doRead(2'd2, 19'h00060, "R2");
    doRead(2'd0, 19'h00070, "R2");
    doneOp();

    // one partition
    writeCfg(3'b000);
    startOp(2'b00, 2'd2);
    doRead(2'd0, 19'h00080, "R2");
    doRead(2'd3, 19'h00090, "R2");
    doneOp();

    // {0,1},{2,3}
    writeCfg(3'b010);
    startOp(2'b00, 2'd0);
    doRead(2'd1, 19'h000A0, "R2");
    doRead(2'd3, 19'h000B0, "R5");
    doneOp();

    // exclusive kinds
    startOp(2'b01, 2'd0);
    doRead(2'd1, 19'h000C0, "R6");
    doRead(2'd3, 19'h000D0, "R6");
    doneOp();
    startOp(2'b10, 2'd2);
    doRead(2'd0, 19'h000E0, "R6");
    doRead(2'd2, 19'h000F0, "R6");
    doneOp();
    doRead(2'd0, 19'h00100, "R11");

    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R3", "responses outstanding", expQ.size(), 0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule